// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

The block collects a vector of level-sensitive interrupt sources and masks it with two separate enable registers, one for each output class. It drives a normal request output and a fast request output. Each output is high while at least one source that its class has enabled is high. Nothing is latched except the enable masks and one software source bit. When a source drops, its request disappears from status and from the outputs. Controllers can be cascaded: one controller's output is wired to a source input of another.

Software reaches the block through a word-addressed register bus with a single-cycle write strobe and a combinational read. Each class has a masked status word, a raw status word, an enable-set address and an enable-clear address, so no read-modify-write is needed. Source 0 can also be raised and lowered by software through a pair of set and clear addresses.

Top module: `lvl_intc_top`

## Requirements
- R1: After reset both enable masks are zero, the software source bit is zero and both outputs are low.
- R2: The effective level is the external source vector, with bit 0 also ORed with the software source bit. Reading word index 1 (normal raw) or word index 9 (fast raw) returns this effective level.
- R3: Reading word index 0 returns the effective level AND the normal enable mask. Reading word index 8 returns the effective level AND the fast enable mask.
- R4: A write to word index 2 ORs the write data into the normal enable mask. A write to word index 10 ORs the write data into the fast enable mask. The normal mask reads back at word index 2 and the fast mask at word index 10.
- R5: A write to word index 3 clears the normal enable bits that are 1 in the write data. A write to word index 11 does the same for the fast enable mask. Bits that are 0 in the data are left unchanged.
- R6: A write to word index 4 with data bit 0 set sets the software source bit. A write to word index 5 with data bit 0 set clears it. When data bit 0 is 0, either write has no effect. Reading word index 4 returns the effective level bit 0 in bit 0 and zero in all other bits.
- R7: Reads of word indices 3, 5 and 11, and of every undecoded index, return zero.
- R8: Writes to the status indices (0, 1, 8, 9) and to undecoded indices change no state.
- R9: irq_o is registered. In the cycle after a clock edge it equals whether (effective level AND normal mask) was nonzero at that edge. fiq_o follows the same rule with the fast mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | External level sources |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A sweep walks a single high source across every position. At each position it enables, in turn, no class, only the normal class and only the fast class, which shows that the two masks act independently and that no bit is dropped or swapped. Overlapping enable-set and enable-clear patterns separate OR and clear semantics from plain overwrite. The software bit is driven alone and together with external source 0, which separates the OR merge from replacement. Every word index is read and written to confirm that the decode is complete.

// File: rtl/lvl_intc_pkg.sv
// Package: shared register index encoding for the level interrupt controller.
// Assumes a 4-bit word index; indices not listed are undecoded.
package lvl_intc_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        IDX_N_STAT  = 4'd0,
        IDX_N_RAW   = 4'd1,
        IDX_N_ENSET = 4'd2,
        IDX_N_ENCLR = 4'd3,
        IDX_SW_SET  = 4'd4,
        IDX_SW_CLR  = 4'd5,
        IDX_F_STAT  = 4'd8,
        IDX_F_RAW   = 4'd9,
        IDX_F_ENSET = 4'd10,
        IDX_F_ENCLR = 4'd11
    } reg_idx_e;
endpackage

// File: rtl/lvl_intc_mask.sv
// Module: one enable mask with write-one-to-set and write-one-to-clear ports,
// plus the masked-any request flop for that class.
// Assumes set and clear are never strobed in the same cycle (decoder is one-hot).
module lvl_intc_mask #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [N-1:0] data,
    input  logic [N-1:0] level,
    output logic [N-1:0] en_q,
    output logic [N-1:0] masked,
    output logic         req_q
);
    // Holds the enable mask, updated by set/clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (set_stb) en_q <= en_q | data;
        else if (clr_stb) en_q <= en_q & ~data;
    end

    // Masked level for status reads.
    always_comb masked = level & en_q;

    // Registers the class request output.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |masked;
    end
endmodule

// File: rtl/lvl_intc_regs.sv
// Module: address decode, software source bit and read multiplexer.
// Assumes a single-cycle write strobe and a combinational read of addr_i.
module lvl_intc_regs
    import lvl_intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      src,
    input  logic [N-1:0]      n_en,
    input  logic [N-1:0]      f_en,
    input  logic [N-1:0]      n_masked,
    input  logic [N-1:0]      f_masked,
    output logic              n_set,
    output logic              n_clr,
    output logic              f_set,
    output logic              f_clr,
    output logic [N-1:0]      level,
    output logic [N-1:0]      rdata
);
    logic sw_q;

    // Decodes write strobes for the enable masks.
    always_comb begin
        n_set = wr_en && (addr == IDX_N_ENSET);
        n_clr = wr_en && (addr == IDX_N_ENCLR);
        f_set = wr_en && (addr == IDX_F_ENSET);
        f_clr = wr_en && (addr == IDX_F_ENCLR);
    end

    // Holds the software-driven source 0 bit.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= 1'b0;
        else if (wr_en && addr == IDX_SW_SET && wdata[0]) sw_q <= 1'b1;
        else if (wr_en && addr == IDX_SW_CLR && wdata[0]) sw_q <= 1'b0;
    end

    // Merges the software bit into source position 0.
    always_comb begin
        level    = src;
        level[0] = src[0] | sw_q;
    end

    // Selects read data by word index.
    always_comb begin
        rdata = '0;
        case (addr)
            IDX_N_STAT:  rdata = n_masked;
            IDX_N_RAW:   rdata = level;
            IDX_N_ENSET: rdata = n_en;
            IDX_SW_SET:  rdata[0] = level[0];
            IDX_F_STAT:  rdata = f_masked;
            IDX_F_RAW:   rdata = level;
            IDX_F_ENSET: rdata = f_en;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/lvl_intc_top.sv
// Module: top of the dual-output level interrupt controller.
// Assumes level-sensitive sources already synchronous to clk.
module lvl_intc_top
    import lvl_intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    output logic [N-1:0]      rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int NCLS = 2;

    logic [N-1:0] level;
    logic [N-1:0] en    [NCLS];
    logic [N-1:0] msk   [NCLS];
    logic         setv  [NCLS];
    logic         clrv  [NCLS];
    logic         req   [NCLS];

    lvl_intc_regs #(.N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
        .wdata(wdata_i), .src(src_i), .n_en(en[0]), .f_en(en[1]),
        .n_masked(msk[0]), .f_masked(msk[1]),
        .n_set(setv[0]), .n_clr(clrv[0]), .f_set(setv[1]), .f_clr(clrv[1]),
        .level(level), .rdata(rdata_o)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        lvl_intc_mask #(.N(N)) u_mask (
            .clk(clk), .rst_n(rst_n), .set_stb(setv[c]), .clr_stb(clrv[c]),
            .data(wdata_i), .level(level), .en_q(en[c]),
            .masked(msk[c]), .req_q(req[c])
        );
    end

    assign irq_o = req[0];
    assign fiq_o = req[1];
endmodule

// File: rtl/lvl_intc_chk.sv
// Checker: port-level properties of lvl_intc_top.
module lvl_intc_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] src_i,
    input logic         wr_en_i,
    input logic [3:0]   addr_i,
    input logic [N-1:0] wdata_i,
    input logic [N-1:0] rdata_o,
    input logic         irq_o,
    input logic         fiq_o
);
    // R1: outputs low in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !fiq_o));

    // R2: both raw indices agree with external sources above bit 0
    a_r2_raw_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 4'd1 || addr_i == 4'd9) |-> (rdata_o[N-1:1] == src_i[N-1:1]));

    // R7: write-only and undecoded indices read zero
    a_r7_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 4'd3 || addr_i == 4'd5 || addr_i == 4'd11 ||
         addr_i == 4'd6 || addr_i == 4'd7 || addr_i > 4'd11) |-> (rdata_o == '0));

    // R6: soft index returns only bit 0
    a_r6_soft_width: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 4'd4) |-> (rdata_o[N-1:1] == '0));

    // R6: source 0 high implies soft readback high
    a_r6_soft_or: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 4'd4 && src_i[0]) |-> rdata_o[0]);

    // R9: with no sources at all for two edges, requests are low
    a_r9_no_src_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0 && addr_i == 4'd1 && rdata_o == '0) |=> (!irq_o && !fiq_o));
endmodule

bind lvl_intc_top lvl_intc_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/tb_lvl_intc_top.sv
module tb_lvl_intc_top;
    localparam int N = 32;
    localparam time TCLK = 10ns;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [N-1:0] src_i = '0;
    logic         wr_en_i = 0;
    logic [3:0]   addr_i = '0;
    logic [N-1:0] wdata_i = '0;
    logic [N-1:0] rdata_o;
    logic         irq_o, fiq_o;

    int total = 0;
    int bad = 0;
    logic done = 0;

    lvl_intc_top #(.N(N)) dut (.*);

    always #(TCLK/2) clk = ~clk;

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [N-1:0] d);
        @(negedge clk);
        wr_en_i = 1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 0; addr_i = 4'd0; wdata_i = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [N-1:0] d);
        @(negedge clk);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    // Settle: one more edge so outputs register current state.
    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(TCLK*150000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] d;
        logic [N-1:0] nm, fm;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", irq_o, 0); chk("R1 fiq", fiq_o, 0);
        rd(4'd2, d); chk("R1 nen", d, 0);
        rd(4'd10, d); chk("R1 fen", d, 0);
        rd(4'd4, d); chk("R1 sw", d, 0);

        // R4/R5 set/clear semantics
        wr(4'd2, 32'hF0F0_00FF); wr(4'd2, 32'h0F00_0100);
        rd(4'd2, d); chk("R4 nen or", d, 32'hFFF0_01FF);
        wr(4'd3, 32'h00F0_0011);
        rd(4'd2, d); chk("R5 nen clr", d, 32'hFF00_01EE);
        rd(4'd10, d); chk("R4 fen untouched", d, 0);
        wr(4'd10, 32'h1234_5678);
        rd(4'd10, d); chk("R4 fen set", d, 32'h1234_5678);
        wr(4'd11, 32'h0000_FFFF);
        rd(4'd10, d); chk("R5 fen clr", d, 32'h1234_0000);
        rd(4'd2, d); chk("R5 nen independent", d, 32'hFF00_01EE);
        wr(4'd3, '1); wr(4'd11, '1);

        // R2/R3/R9 walking source across all positions and class configs
        for (int p = 0; p < N; p++) begin
            for (int cfg = 0; cfg < 3; cfg++) begin
                nm = (cfg == 1) ? (32'h1 << p) : '0;
                fm = (cfg == 2) ? (32'h1 << p) : '0;
                wr(4'd3, '1); wr(4'd11, '1);
                if (cfg == 1) wr(4'd2, nm);
                if (cfg == 2) wr(4'd10, fm);
                @(negedge clk);
                src_i = 32'h1 << p;
                settle();
                rd(4'd1, d); chk("R2 raw", d, 32'h1 << p);
                rd(4'd9, d); chk("R2 fraw", d, 32'h1 << p);
                rd(4'd0, d); chk("R3 nstat", d, (32'h1 << p) & nm);
                rd(4'd8, d); chk("R3 fstat", d, (32'h1 << p) & fm);
                chk("R9 irq", irq_o, cfg == 1);
                chk("R9 fiq", fiq_o, cfg == 2);
                src_i = '0;
            end
        end
        wr(4'd3, '1); wr(4'd11, '1);

        // R9 timing: output one edge after source change
        wr(4'd2, 32'h8);
        @(negedge clk);
        src_i = 32'h8;
        #1 chk("R9 not yet", irq_o, 0);
        @(negedge clk);
        chk("R9 one edge", irq_o, 1);
        src_i = 0;
        @(negedge clk);
        chk("R9 drop", irq_o, 0);
        wr(4'd3, '1);

        // R6 software bit
        wr(4'd4, 32'hFFFF_FFFE);
        rd(4'd4, d); chk("R6 bit0 zero no effect", d, 0);
        wr(4'd4, 32'h1);
        rd(4'd4, d); chk("R6 set", d, 1);
        rd(4'd1, d); chk("R6 raw sw", d, 1);
        wr(4'd10, 32'h1);
        settle(); chk("R6 fiq from sw", fiq_o, 1);
        chk("R6 irq stays", irq_o, 0);
        src_i = 32'h1;
        wr(4'd5, 32'h1);
        rd(4'd4, d); chk("R6 ext keeps bit0", d, 1);
        src_i = 0;
        rd(4'd4, d); chk("R6 cleared", d, 0);
        wr(4'd4, 32'h1); wr(4'd5, 32'h0);
        rd(4'd4, d); chk("R6 clr bit0 zero no effect", d, 1);
        wr(4'd5, 32'h1); wr(4'd11, '1);

        // R7 reads of write-only and undecoded indices
        src_i = '1; wr(4'd2, '1); wr(4'd10, '1); wr(4'd4, 1);
        for (int a = 0; a < 16; a++) begin
            if (a == 3 || a == 5 || a == 6 || a == 7 || a >= 11) begin
                rd(a[3:0], d); chk("R7 zero read", d, 0);
            end
        end

        // R8 writes to status/undecoded indices change nothing
        wr(4'd5, 1); wr(4'd3, 32'h0000_FFFF); wr(4'd11, 32'hFFFF_0000);
        src_i = '0;
        foreach (d[i]) ;
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a == 1 || a == 6 || a == 7 || a == 8 || a == 9 || a >= 12)
                wr(a[3:0], '1);
        end
        rd(4'd2, d); chk("R8 nen kept", d, 32'hFFFF_0000);
        rd(4'd10, d); chk("R8 fen kept", d, 32'h0000_FFFF);
        rd(4'd4, d); chk("R8 sw kept", d, 0);

        // R1 reset clears state
        wr(4'd4, 1);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(4'd2, d); chk("R1 nen after reset", d, 0);
        rd(4'd4, d); chk("R1 sw after reset", d, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule